// File: doc/BRIEF.md
# Multiply-Accumulate Product Scaling and Saturation Core

This block holds the arithmetic around the accumulators of a multiply-accumulate unit. The accumulators and the instruction decode live elsewhere. It has three independent single-cycle paths, each with its own valid strobe and a registered result.

The product path multiplies two 32-bit operands. It returns a 64-bit value that is ready to be added into an accumulator. The value is an integer product checked against a 40-bit range, or a fractional product scaled down by 24 bits. The saturation path takes an accumulator value and checks it against a 48-bit range. It then clamps or masks the value before the value is written back. The readout path reduces an accumulator value to a 32-bit or 16-bit word, with optional rounding and clamping.

Four mode inputs select the arithmetic for all three paths: clamp-on-overflow, fractional select, unsigned select and round enable. A sticky overflow flag and one overflow flag per accumulator record what the product and saturation paths detect. Only an explicit status write clears them.

Top module: `mac_scale_sat`

## Requirements
- R1: While `rst` is high, every valid output, every data output, `v_flag` and `acc_ovf` are zero.
- R2: Each path raises its output valid exactly one cycle after its input strobe, for one cycle. Between strobes the data output holds its last value.
- R3: Signed integer product (`frac_mode`=0, `uns_mode`=0). The 64-bit signed product overflows when it is not the sign extension of its low 40 bits. An overflow sets `v_flag`. Without clamping, the output is the sign extension of the low 40 bits.
- R4: A signed product overflow with `omc`=1 outputs 2^50 for a non-negative product. It outputs the bitwise complement of 2^50 for a negative product.
- R5: Unsigned product (`frac_mode`=0, `uns_mode`=1). Any set bit in product bits 63..40 is an overflow and sets `v_flag`. The output is then 2^50 with `omc`=1, or the low 40 bits of the product with `omc`=0.
- R6: Fractional product (`frac_mode`=1). The signed product is shifted right arithmetically by 24. With `round_en`=1, a discarded 24-bit remainder above 0x800000 adds one, and a remainder equal to 0x800000 adds the result's bit 0. The fractional product never sets `v_flag`.
- R7: Signed integer saturation overflows when the input is not the sign extension of its low 48 bits. Overflow sets `v_flag`. If the effective flag (old `v_flag` or this overflow) is set and `omc`=1, the output is 0x7FFFFFFF, or 0xFFFFFFFF80000000 when bit 63 of the 48-bit sign extension is set. Otherwise the output is that sign extension.
- R8: Unsigned saturation overflows on any set bit in 63..48. With the effective flag set and `omc`=1, the output is 0 when the input exceeds 2^53, and 2^48-1 otherwise. With the effective flag set and `omc`=0, the output is the low 48 bits. Otherwise the input passes unchanged.
- R9: Fractional saturation uses the same 48-bit check as R7, but it clamps to 0x00007FFFFFFFFFFF or 0xFFFF800000000000.
- R10: A saturation strobe whose effective flag is set (old `v_flag` or a new overflow) sets `acc_ovf[sat_sel]`. A sticky `v_flag` alone is enough to clamp an in-range value.
- R11: `v_flag` and `acc_ovf` change only by setting, except through a status write (`stat_wr`=1). A write loads `stat_wr_v` and `stat_wr_ovf`, and it takes priority over any set in the same cycle.
- R12: Fractional 16-bit readout (`rd_half`=1) takes bits 39..24 and always rounds half-to-even on bits 23..0. A carry out of 16 bits gives 0x7FFF with `omc`=1, and the wrapped low 16 bits with `omc`=0. The value is zero-extended to 32 bits.
- R13: Fractional 32-bit readout (`rd_half`=0) shifts right by 8. With `round_en`=1 it rounds half-to-even on the low 8 bits. A result wider than 32 bits gives 0x7FFFFFFF with `omc`=1, and the low 32 bits with `omc`=0.
- R14: Integer readout. In signed mode a value outside the signed 32-bit range gives 0x7FFFFFFF if positive and 0x80000000 if negative. In unsigned mode a non-zero upper half gives 0xFFFFFFFF. Otherwise the low 32 bits are returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| omc | input | 1 | Clamp on overflow |
| frac_mode | input | 1 | Fractional arithmetic select |
| uns_mode | input | 1 | Unsigned integer select (when not fractional) |
| round_en | input | 1 | Round enable |
| rd_half | input | 1 | 16-bit fractional readout |
| mul_valid | input | 1 | Product strobe |
| mul_a | input | 32 | First operand |
| mul_b | input | 32 | Second operand |
| prod_valid | output | 1 | Product result valid |
| prod_out | output | 64 | Scaled product |
| sat_valid | input | 1 | Saturation strobe |
| sat_sel | input | 2 | Accumulator index |
| sat_in | input | 64 | Accumulator value to check |
| sat_out_valid | output | 1 | Saturation result valid |
| sat_out | output | 64 | Saturated value |
| rd_valid | input | 1 | Readout strobe |
| rd_val | input | 64 | Accumulator value to read |
| rd_out_valid | output | 1 | Readout result valid |
| rd_out | output | 32 | Readout word |
| stat_wr | input | 1 | Status write |
| stat_wr_v | input | 1 | Value written to the sticky flag |
| stat_wr_ovf | input | 4 | Values written to the per-accumulator flags |
| v_flag | output | 1 | Sticky overflow flag |
| acc_ovf | output | 4 | Per-accumulator overflow flags |

## Verification
The product path is swept over every pair from a 13-value operand set, in every mode and both clamp settings.

The operand set mixes extremes, sign changes and values whose products fall exactly on the 40-bit signed boundary. Such a product separates the signed overflow check from the unsigned one. The set also contains operands whose products leave a remainder of exactly 0x800000, which tests rounding to even.

Saturation values are chosen on both sides of the 48-bit limits and of 2^53. Each is applied with the sticky flag both clear and preset, so clamping by a fresh overflow is told apart from clamping by a stored one.

Readout values place ties and round-up carries at bit 8 and at bit 24. They also sit on both edges of the signed and unsigned 32-bit ranges.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int OP_W        = 32;
    localparam int WIDE_W      = 2 * OP_W;
    localparam int PROD_KEEP_W = 40;
    localparam int ACC_W       = 48;
    localparam int FRAC_SH     = 24;
    localparam int RD_SH       = 8;
    localparam int HALF_W      = 16;
    localparam int CLAMP_POS   = 50;
    localparam int USAT_POS    = 53;

    localparam logic [WIDE_W-1:0] ONE_W        = 1;
    localparam logic [WIDE_W-1:0] PROD_FORCE   = ONE_W << CLAMP_POS;
    localparam logic [WIDE_W-1:0] KEEP_MASK    = (ONE_W << PROD_KEEP_W) - ONE_W;
    localparam logic [WIDE_W-1:0] ACC_MASK     = (ONE_W << ACC_W) - ONE_W;
    localparam logic [WIDE_W-1:0] ACC_POS_MAX  = (ONE_W << (ACC_W - 1)) - ONE_W;
    localparam logic [WIDE_W-1:0] WIDE_WORDMAX = (ONE_W << (OP_W - 1)) - ONE_W;
    localparam logic [WIDE_W-1:0] USAT_LIMIT   = ONE_W << USAT_POS;

    localparam logic [OP_W-1:0]    WORD_POS_MAX = {1'b0, {(OP_W-1){1'b1}}};
    localparam logic [OP_W-1:0]    WORD_NEG_MIN = {1'b1, {(OP_W-1){1'b0}}};
    localparam logic [HALF_W-1:0]  HALF_POS_MAX = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [FRAC_SH-1:0] FRAC_TIE     = {1'b1, {(FRAC_SH-1){1'b0}}};
    localparam logic [RD_SH-1:0]   RD_TIE       = {1'b1, {(RD_SH-1){1'b0}}};

    typedef enum logic [1:0] {
        AR_SINT = 2'd0,
        AR_UINT = 2'd1,
        AR_FRAC = 2'd2
    } arith_e;

    typedef struct packed {
        logic              valid;
        logic [WIDE_W-1:0] data;
    } wide_beat_t;

    typedef struct packed {
        logic            valid;
        logic [OP_W-1:0] data;
    } word_beat_t;

    function automatic arith_e arith_sel(input logic frac, input logic uns);
        if (frac) return AR_FRAC;
        if (uns)  return AR_UINT;
        return AR_SINT;
    endfunction

    function automatic logic [WIDE_W-1:0] sext_from(input logic [WIDE_W-1:0] v,
                                                     input int w);
        logic signed [WIDE_W-1:0] t;
        t = v << (WIDE_W - w);
        return t >>> (WIDE_W - w);
    endfunction

    // half-to-even increment decision
    function automatic logic rne_inc(input logic lsb, input logic above, input logic tie);
        return above | (tie & lsb);
    endfunction

endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    input  arith_e            arith,
    input  logic              omc,
    input  logic              round_en,
    output wide_beat_t        beat,
    output logic              ovf_hit
);

    logic signed [WIDE_W-1:0] s_prod;
    logic [WIDE_W-1:0]        u_prod;
    logic [WIDE_W-1:0]        s_trunc;
    logic [WIDE_W-1:0]        frac_q;
    logic [FRAC_SH-1:0]       frac_rem;
    logic                     frac_inc;
    logic                     s_ovf;
    logic                     u_ovf;
    logic [WIDE_W-1:0]        nxt;
    logic                     hit;

    assign s_prod   = {{OP_W{op_a[OP_W-1]}}, op_a} * {{OP_W{op_b[OP_W-1]}}, op_b};
    assign u_prod   = {{OP_W{1'b0}}, op_a} * {{OP_W{1'b0}}, op_b};
    assign s_trunc  = sext_from(s_prod, PROD_KEEP_W);
    assign s_ovf    = (s_trunc != s_prod);
    assign u_ovf    = |u_prod[WIDE_W-1:PROD_KEEP_W];
    assign frac_q   = s_prod >>> FRAC_SH;
    assign frac_rem = s_prod[FRAC_SH-1:0];
    assign frac_inc = round_en & rne_inc(frac_q[0], frac_rem > FRAC_TIE, frac_rem == FRAC_TIE);

    always_comb begin
        nxt = s_trunc;
        hit = 1'b0;
        case (arith)
            AR_SINT: begin
                hit = s_ovf;
                if (s_ovf && omc)
                    nxt = s_prod[WIDE_W-1] ? ~PROD_FORCE : PROD_FORCE;
            end
            AR_UINT: begin
                hit = u_ovf;
                if (!u_ovf)   nxt = u_prod;
                else if (omc) nxt = PROD_FORCE;
                else          nxt = u_prod & KEEP_MASK;
            end
            default: begin
                nxt = frac_q + {{(WIDE_W-1){1'b0}}, frac_inc};
            end
        endcase
    end

    assign ovf_hit = in_valid & hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= in_valid;
            if (in_valid) beat.data <= nxt;
        end
    end

endmodule

// File: rtl/mac_sat_stage.sv
module mac_sat_stage
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WIDE_W-1:0] acc_in,
    input  arith_e            arith,
    input  logic              omc,
    input  logic              v_now,
    output wide_beat_t        beat,
    output logic              ovf_hit,
    output logic              flag_en
);

    logic [WIDE_W-1:0] sx;
    logic              s_ovf;
    logic              u_ovf;
    logic              ovf;
    logic              eff;
    logic [WIDE_W-1:0] nxt;

    assign sx    = sext_from(acc_in, ACC_W);
    assign s_ovf = (sx != acc_in);
    assign u_ovf = |acc_in[WIDE_W-1:ACC_W];
    assign ovf   = (arith == AR_UINT) ? u_ovf : s_ovf;
    assign eff   = v_now | ovf;

    always_comb begin
        nxt = sx;
        case (arith)
            AR_SINT: begin
                if (eff && omc) nxt = sx[WIDE_W-1] ? ~WIDE_WORDMAX : WIDE_WORDMAX;
            end
            AR_UINT: begin
                if (!eff)                  nxt = acc_in;
                else if (!omc)             nxt = acc_in & ACC_MASK;
                else if (acc_in > USAT_LIMIT) nxt = '0;
                else                       nxt = ACC_MASK;
            end
            default: begin
                if (eff && omc) nxt = sx[WIDE_W-1] ? ~ACC_POS_MAX : ACC_POS_MAX;
            end
        endcase
    end

    assign ovf_hit = in_valid & ovf;
    assign flag_en = in_valid & eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= in_valid;
            if (in_valid) beat.data <= nxt;
        end
    end

endmodule

// File: rtl/mac_read_stage.sv
module mac_read_stage
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WIDE_W-1:0] acc_val,
    input  arith_e            arith,
    input  logic              half,
    input  logic              omc,
    input  logic              round_en,
    output word_beat_t        beat
);

    localparam int SH_W = WIDE_W - RD_SH + 1;

    logic [HALF_W:0]      seg;
    logic [FRAC_SH-1:0]   seg_rem;
    logic                 seg_inc;
    logic [HALF_W:0]      seg_r;
    logic [HALF_W-1:0]    half_res;

    logic [SH_W-1:0]      wsh;
    logic [RD_SH-1:0]     wrem;
    logic                 w_inc;
    logic [SH_W-1:0]      wsh_r;
    logic                 w_fits;
    logic [OP_W-1:0]      word_res;

    logic                 s_fits;
    logic [OP_W-1:0]      nxt;

    // 16-bit fractional: always rounded
    assign seg      = {1'b0, acc_val[FRAC_SH+HALF_W-1:FRAC_SH]};
    assign seg_rem  = acc_val[FRAC_SH-1:0];
    assign seg_inc  = rne_inc(seg[0], seg_rem > FRAC_TIE, seg_rem == FRAC_TIE);
    assign seg_r    = seg + {{HALF_W{1'b0}}, seg_inc};
    assign half_res = (omc && seg_r[HALF_W]) ? HALF_POS_MAX : seg_r[HALF_W-1:0];

    // 32-bit fractional: optional rounding
    assign wsh      = {1'b0, acc_val[WIDE_W-1:RD_SH]};
    assign wrem     = acc_val[RD_SH-1:0];
    assign w_inc    = round_en & rne_inc(wsh[0], wrem > RD_TIE, wrem == RD_TIE);
    assign wsh_r    = wsh + {{(SH_W-1){1'b0}}, w_inc};
    assign w_fits   = ~|wsh_r[SH_W-1:OP_W];
    assign word_res = (omc && !w_fits) ? WORD_POS_MAX : wsh_r[OP_W-1:0];

    assign s_fits   = (&acc_val[WIDE_W-1:OP_W-1]) | ~(|acc_val[WIDE_W-1:OP_W-1]);

    always_comb begin
        case (arith)
            AR_SINT: begin
                if (s_fits)                  nxt = acc_val[OP_W-1:0];
                else if (acc_val[WIDE_W-1])  nxt = WORD_NEG_MIN;
                else                         nxt = WORD_POS_MAX;
            end
            AR_UINT: begin
                nxt = (|acc_val[WIDE_W-1:OP_W]) ? '1 : acc_val[OP_W-1:0];
            end
            default: begin
                nxt = half ? {{(OP_W-HALF_W){1'b0}}, half_res} : word_res;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid <= in_valid;
            if (in_valid) beat.data <= nxt;
        end
    end

endmodule

// File: rtl/mac_status_reg.sv
module mac_status_reg #(
    parameter int NUM_ACC = 4,
    localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mul_hit,
    input  logic               sat_hit,
    input  logic               flag_en,
    input  logic [SEL_W-1:0]   flag_sel,
    input  logic               wr,
    input  logic               wr_v,
    input  logic [NUM_ACC-1:0] wr_ovf,
    output logic               v_flag,
    output logic [NUM_ACC-1:0] acc_ovf
);

    logic [NUM_ACC-1:0] set_vec;

    for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_flag
        assign set_vec[gi] = flag_en && (flag_sel == SEL_W'(gi));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_flag  <= 1'b0;
            acc_ovf <= '0;
        end else if (wr) begin
            v_flag  <= wr_v;
            acc_ovf <= wr_ovf;
        end else begin
            v_flag  <= v_flag | mul_hit | sat_hit;
            acc_ovf <= acc_ovf | set_vec;
        end
    end

endmodule

// File: rtl/mac_scale_sat.sv
module mac_scale_sat
    import mac_pkg::*;
#(
    parameter int NUM_ACC = 4,
    localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               omc,
    input  logic               frac_mode,
    input  logic               uns_mode,
    input  logic               round_en,
    input  logic               rd_half,
    input  logic               mul_valid,
    input  logic [OP_W-1:0]    mul_a,
    input  logic [OP_W-1:0]    mul_b,
    output logic               prod_valid,
    output logic [WIDE_W-1:0]  prod_out,
    input  logic               sat_valid,
    input  logic [SEL_W-1:0]   sat_sel,
    input  logic [WIDE_W-1:0]  sat_in,
    output logic               sat_out_valid,
    output logic [WIDE_W-1:0]  sat_out,
    input  logic               rd_valid,
    input  logic [WIDE_W-1:0]  rd_val,
    output logic               rd_out_valid,
    output logic [OP_W-1:0]    rd_out,
    input  logic               stat_wr,
    input  logic               stat_wr_v,
    input  logic [NUM_ACC-1:0] stat_wr_ovf,
    output logic               v_flag,
    output logic [NUM_ACC-1:0] acc_ovf
);

    arith_e     arith;
    wide_beat_t mul_beat;
    wide_beat_t sat_beat;
    word_beat_t rd_beat;
    logic       mul_hit;
    logic       sat_hit;
    logic       sat_flag_en;

    assign arith = arith_sel(frac_mode, uns_mode);

    mac_mul_stage u_mul (
        .clk      (clk),
        .rst      (rst),
        .in_valid (mul_valid),
        .op_a     (mul_a),
        .op_b     (mul_b),
        .arith    (arith),
        .omc      (omc),
        .round_en (round_en),
        .beat     (mul_beat),
        .ovf_hit  (mul_hit)
    );

    mac_sat_stage u_sat (
        .clk      (clk),
        .rst      (rst),
        .in_valid (sat_valid),
        .acc_in   (sat_in),
        .arith    (arith),
        .omc      (omc),
        .v_now    (v_flag),
        .beat     (sat_beat),
        .ovf_hit  (sat_hit),
        .flag_en  (sat_flag_en)
    );

    mac_read_stage u_rd (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rd_valid),
        .acc_val  (rd_val),
        .arith    (arith),
        .half     (rd_half),
        .omc      (omc),
        .round_en (round_en),
        .beat     (rd_beat)
    );

    mac_status_reg #(.NUM_ACC(NUM_ACC)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .mul_hit  (mul_hit),
        .sat_hit  (sat_hit),
        .flag_en  (sat_flag_en),
        .flag_sel (sat_sel),
        .wr       (stat_wr),
        .wr_v     (stat_wr_v),
        .wr_ovf   (stat_wr_ovf),
        .v_flag   (v_flag),
        .acc_ovf  (acc_ovf)
    );

    assign prod_valid    = mul_beat.valid;
    assign prod_out      = mul_beat.data;
    assign sat_out_valid = sat_beat.valid;
    assign sat_out       = sat_beat.data;
    assign rd_out_valid  = rd_beat.valid;
    assign rd_out        = rd_beat.data;

endmodule

// File: rtl/mac_scale_sat_chk.sv
module mac_scale_sat_chk
    import mac_pkg::*;
#(
    parameter int NUM_ACC = 4,
    localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               frac_mode,
    input logic               uns_mode,
    input logic               mul_valid,
    input logic               prod_valid,
    input logic               sat_valid,
    input logic [SEL_W-1:0]   sat_sel,
    input logic               sat_out_valid,
    input logic               rd_valid,
    input logic [WIDE_W-1:0]  rd_val,
    input logic               rd_out_valid,
    input logic [OP_W-1:0]    rd_out,
    input logic               stat_wr,
    input logic               stat_wr_v,
    input logic [NUM_ACC-1:0] stat_wr_ovf,
    input logic               v_flag,
    input logic [NUM_ACC-1:0] acc_ovf
);

    p_mul_latency_r2: assert property (@(posedge clk) disable iff (rst)
        mul_valid |=> prod_valid);

    p_sat_latency_r2: assert property (@(posedge clk) disable iff (rst)
        sat_valid |=> sat_out_valid);

    p_rd_latency_r2: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> rd_out_valid);

    p_frac_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (mul_valid && frac_mode && !sat_valid && !stat_wr && !v_flag) |=> !v_flag);

    p_flag_on_v_r10: assert property (@(posedge clk) disable iff (rst)
        (sat_valid && v_flag && !stat_wr) |=> acc_ovf[$past(sat_sel)]);

    p_v_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (v_flag && !stat_wr) |=> v_flag);

    p_ovf_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((acc_ovf & $past(acc_ovf)) == $past(acc_ovf)));

    p_wr_load_r11: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> (v_flag == $past(stat_wr_v)) && (acc_ovf == $past(stat_wr_ovf)));

    p_uint_read_r14: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !frac_mode && uns_mode && (rd_val[WIDE_W-1:OP_W] != '0))
        |=> (rd_out == '1));

endmodule

bind mac_scale_sat mac_scale_sat_chk #(.NUM_ACC(NUM_ACC)) u_chk (.*);

// File: tb/mac_scale_sat_test.sv
module mac_scale_sat_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        omc = 1'b0, frac_mode = 1'b0, uns_mode = 1'b0, round_en = 1'b0, rd_half = 1'b0;
    logic        mul_valid = 1'b0;
    logic [31:0] mul_a = '0, mul_b = '0;
    logic        prod_valid;
    logic [63:0] prod_out;
    logic        sat_valid = 1'b0;
    logic [1:0]  sat_sel = '0;
    logic [63:0] sat_in = '0;
    logic        sat_out_valid;
    logic [63:0] sat_out;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_val = '0;
    logic        rd_out_valid;
    logic [31:0] rd_out;
    logic        stat_wr = 1'b0, stat_wr_v = 1'b0;
    logic [3:0]  stat_wr_ovf = '0;
    logic        v_flag;
    logic [3:0]  acc_ovf;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_scale_sat uut (.*);

    bit [31:0] mul_ops [13] = '{32'd0, 32'd1, 32'd3, 32'hFFFFFFFF, 32'hFFFFFFFD,
                                32'h7FFFFFFF, 32'h80000000, 32'h00800000, 32'h00010000,
                                32'hFFFF0000, 32'h12345678, 32'h00C00001, 32'h40000000};

    bit [63:0] sat_vals [12] = '{64'd0, 64'd5, 64'h00007FFFFFFFFFFF, 64'h0000800000000000,
                                 64'hFFFFFFFFFFFFFFFF, 64'hFFFF800000000000, 64'hFFFF7FFFFFFFFFFF,
                                 64'h0001000000000000, 64'h0020000000000000, 64'h0020000000000001,
                                 64'h0000123456789ABC, 64'h8000000000000000};

    bit [63:0] rd_vals [13] = '{64'h0000000001800000, 64'h0000000000800000, 64'h000000FFFF800001,
                                64'h0000000000000180, 64'h0000000000000080, 64'h0000000000000081,
                                64'h000000FFFFFFFFFF, 64'h000000007FFFFFFF, 64'h0000000080000000,
                                64'hFFFFFFFF80000000, 64'hFFFFFFFF7FFFFFFF, 64'h0000000100000000,
                                64'hFFFFFFFFFFFFFFFF};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit [63:0] sx(input bit [63:0] v, input int w);
        longint t;
        t = longint'(v << (64 - w));
        return t >>> (64 - w);
    endfunction

    function automatic bit [63:0] rnd(input bit [63:0] q, input bit [63:0] r, input bit [63:0] tie);
        if (r > tie) return q + 1;
        if (r == tie) return q + (q & 1);
        return q;
    endfunction

    function automatic void mul_model(input bit [31:0] a, input bit [31:0] b, input int m,
                                      input bit clamp, output bit [63:0] val, output bit ov);
        int sa, sb;
        longint sp;
        bit [63:0] up;
        sa = a; sb = b;
        sp = longint'(sa) * longint'(sb);
        up = {32'd0, a} * {32'd0, b};
        ov = 0;
        case (m)
            0: begin
                ov = ((sp >>> 39) != 0) && ((sp >>> 39) != -1);
                if (ov && clamp) val = (sp < 0) ? ~(64'd1 << 50) : (64'd1 << 50);
                else             val = sx(sp, 40);
            end
            1: begin
                ov = (up >> 40) != 0;
                if (!ov)        val = up;
                else if (clamp) val = 64'd1 << 50;
                else            val = up & ((64'd1 << 40) - 1);
            end
            default: begin
                val = sp >>> 24;
                if (m == 2) val = rnd(val, sp & 64'hFFFFFF, 64'h800000);
            end
        endcase
    endfunction

    function automatic void sat_model(input bit [63:0] x, input int m, input bit clamp,
                                      input bit vpre, output bit [63:0] val,
                                      output bit ov, output bit eff);
        bit [63:0] s;
        s = sx(x, 48);
        ov = (m == 1) ? ((x >> 48) != 0) : (s != x);
        eff = vpre | ov;
        case (m)
            0: val = (eff && clamp) ? (s[63] ? 64'hFFFFFFFF80000000 : 64'h7FFFFFFF) : s;
            1: begin
                if (!eff)                      val = x;
                else if (!clamp)               val = x & ((64'd1 << 48) - 1);
                else if (x > (64'd1 << 53))    val = 0;
                else                           val = (64'd1 << 48) - 1;
            end
            default: val = (eff && clamp) ? (s[63] ? 64'hFFFF800000000000 : 64'h00007FFFFFFFFFFF) : s;
        endcase
    endfunction

    function automatic bit [31:0] rd_model(input bit [63:0] v, input int rm, input bit clamp);
        bit [63:0] s;
        longint sv;
        case (rm)
            0: begin
                s = rnd((v >> 24) & 64'hFFFF, v & 64'hFFFFFF, 64'h800000);
                if (s > 64'hFFFF) return clamp ? 32'h7FFF : 32'(s & 64'hFFFF);
                return 32'(s);
            end
            1, 2: begin
                s = v >> 8;
                if (rm == 1) s = rnd(s, v & 64'hFF, 64'h80);
                if (s > 64'hFFFFFFFF && clamp) return 32'h7FFFFFFF;
                return s[31:0];
            end
            3: begin
                sv = v;
                if (sv >= -64'sd2147483648 && sv <= 64'sd2147483647) return v[31:0];
                return (sv < 0) ? 32'h80000000 : 32'h7FFFFFFF;
            end
            default: return ((v >> 32) == 0) ? v[31:0] : 32'hFFFFFFFF;
        endcase
    endfunction

    task automatic wr_status(input bit v, input bit [3:0] f);
        @(negedge clk);
        stat_wr = 1; stat_wr_v = v; stat_wr_ovf = f;
        @(negedge clk);
        stat_wr = 0;
    endtask

    task automatic do_mul(input bit [31:0] a, input bit [31:0] b);
        @(negedge clk);
        mul_a = a; mul_b = b; mul_valid = 1;
        @(negedge clk);
        mul_valid = 0;
    endtask

    task automatic do_sat(input bit [63:0] x, input bit [1:0] sel);
        @(negedge clk);
        sat_in = x; sat_sel = sel; sat_valid = 1;
        @(negedge clk);
        sat_valid = 0;
    endtask

    task automatic do_rd(input bit [63:0] x);
        @(negedge clk);
        rd_val = x; rd_valid = 1;
        @(negedge clk);
        rd_valid = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", WATCHDOG, WATCHDOG);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        bit [63:0] ev;
        bit        eo, ee;
        string     tag;

        // R1: state during reset
        repeat (3) @(negedge clk);
        check("R1 prod_valid", prod_valid, 0);
        check("R1 prod_out", prod_out, 0);
        check("R1 sat_out", sat_out, 0);
        check("R1 rd_out", rd_out, 0);
        check("R1 v_flag", v_flag, 0);
        check("R1 acc_ovf", acc_ovf, 0);
        rst = 0;

        // R2: one-cycle latency, single-cycle valid, data hold
        do_mul(32'd6, 32'd7);
        check("R2 prod_valid up", prod_valid, 1);
        check("R2 prod_out", prod_out, 64'd42);
        @(negedge clk);
        check("R2 prod_valid down", prod_valid, 0);
        check("R2 prod_out hold", prod_out, 64'd42);
        do_sat(64'd9, 2'd0);
        check("R2 sat_out_valid", sat_out_valid, 1);
        do_rd(64'd11);
        check("R2 rd_out_valid", rd_out_valid, 1);
        @(negedge clk);
        check("R2 rd_out_valid down", rd_out_valid, 0);

        // R3..R6: product sweep
        for (int m = 0; m < 4; m++) begin
            frac_mode = (m >= 2); uns_mode = (m == 1); round_en = (m == 2);
            for (int o = 0; o < 2; o++) begin
                omc = o[0];
                tag = (m == 0) ? (o ? "R4" : "R3") : ((m == 1) ? "R5" : "R6");
                for (int i = 0; i < 13; i++) begin
                    for (int j = 0; j < 13; j++) begin
                        mul_model(mul_ops[i], mul_ops[j], m, o[0], ev, eo);
                        wr_status(0, 4'b0);
                        do_mul(mul_ops[i], mul_ops[j]);
                        check({tag, " product"}, prod_out, ev);
                        check({tag, " v_flag"}, v_flag, eo);
                    end
                end
            end
        end

        // R7..R10: saturation sweep with V clear and preset
        for (int m = 0; m < 3; m++) begin
            frac_mode = (m == 2); uns_mode = (m == 1); round_en = 0;
            tag = (m == 0) ? "R7" : ((m == 1) ? "R8" : "R9");
            for (int o = 0; o < 2; o++) begin
                omc = o[0];
                for (int vp = 0; vp < 2; vp++) begin
                    for (int k = 0; k < 12; k++) begin
                        sat_model(sat_vals[k], m, o[0], vp[0], ev, eo, ee);
                        wr_status(vp[0], 4'b0);
                        do_sat(sat_vals[k], 2'(k));
                        check({tag, " sat_out"}, sat_out, ev);
                        check({tag, " v_flag"}, v_flag, vp[0] | eo);
                        check("R10 acc_ovf", acc_ovf, ee ? (64'd1 << (k % 4)) : 64'd0);
                    end
                end
            end
        end

        // R11: stickiness, clearing only by write, write priority
        frac_mode = 0; uns_mode = 0; omc = 0;
        wr_status(0, 4'b0);
        do_mul(32'h40000000, 32'h40000000);
        check("R11 v set", v_flag, 1);
        do_mul(32'd2, 32'd3);
        do_rd(64'd1);
        check("R11 v sticky", v_flag, 1);
        do_sat(64'h0000800000000000, 2'd3);
        do_sat(64'd4, 2'd1);
        check("R11 ovf sticky", acc_ovf, 4'b1010);
        @(negedge clk);
        mul_a = 32'h40000000; mul_b = 32'h40000000; mul_valid = 1;
        sat_in = 64'h0000800000000000; sat_sel = 2'd0; sat_valid = 1;
        stat_wr = 1; stat_wr_v = 0; stat_wr_ovf = 4'b0100;
        @(negedge clk);
        mul_valid = 0; sat_valid = 0; stat_wr = 0;
        check("R11 write wins v", v_flag, 0);
        check("R11 write wins ovf", acc_ovf, 4'b0100);
        @(negedge clk);
        check("R11 write held", acc_ovf, 4'b0100);

        // R12..R14: readout sweep
        for (int rm = 0; rm < 5; rm++) begin
            frac_mode = (rm <= 2); uns_mode = (rm == 4);
            rd_half = (rm == 0); round_en = (rm == 1);
            tag = (rm == 0) ? "R12" : ((rm <= 2) ? "R13" : "R14");
            for (int o = 0; o < 2; o++) begin
                omc = o[0];
                for (int k = 0; k < 13; k++) begin
                    do_rd(rd_vals[k]);
                    check({tag, " rd_out"}, rd_out, rd_model(rd_vals[k], rm, o[0]));
                end
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule